// File: doc/BRIEF.md
# Quad SPI Phase Engine

This block is a generic quad SPI master. It does not build in any command set for a particular memory. Software builds a transaction itself by running one phase at a time. The available phases are:

- a command byte on one lane or on four lanes,
- a 32-bit address,
- a 24-bit alternate word,
- a two-cycle turnaround with the lanes released,
- a 32-bit quad read.

Chip select can be held low across several phases, so a complete flash-style access is simply a sequence of register writes.

The engine runs in SPI mode 0, so the serial clock idles low. Transmit data changes while the clock is low. Read data belongs to the falling edge of the serial clock, but the engine captures each nibble one system clock after that edge. This absorbs the round-trip delay of the pads and any external level shifters. The serial clock runs at the system clock divided by `2*HALF_DIV`.

Software reaches the engine through four 32-bit words. They are selected by `reg_addr`: 0 = transmit data, 1 = received data, 2 = control, 3 = status.

Top module: `qspe_phase_engine`

## Requirements
- R1: After reset, `qspi_cs_n` is 1, `qspi_sclk` is 0 and `qspi_dq_oe` is 0. The control, status and received-data words all read 0.
- R2: Phase code 0 sends bits 7:0 of the transmit word, most significant bit first, on lane 0 only (`qspi_dq_oe` = 0001). It takes 8 serial clocks.
- R3: Phase code 1 sends bits 7:0 of the transmit word as two nibbles on all four lanes (`qspi_dq_oe` = 1111), high nibble first.
- R4: Phase code 2 sends all 32 bits of the transmit word on four lanes in 8 serial clocks, most significant nibble first.
- R5: Phase code 3 sends bits 23:0 of the transmit word on four lanes in 6 serial clocks, most significant nibble first.
- R6: Phase code 4 produces exactly 2 serial clocks with `qspi_dq_oe` = 0.
- R7: Phase code 5 holds `qspi_dq_oe` at 0 for 8 serial clocks. It captures `qspi_dq_i` one system clock after each falling serial clock edge and builds the received word with the first nibble in bits 31:28. When the phase ends, status bit 2 (read valid) is set.
- R8: The serial clock is low whenever the engine is idle. Each half period lasts `HALF_DIV` system clocks. Status bit 0 (busy) stays high for `2*HALF_DIV*N+1` cycles for an N-clock phase.
- R9: Writing the control word with bit 31 set starts a phase. This start clears status bit 1 (done) and status bit 2 (read valid). Done sets in the cycle in which busy clears.
- R10: `qspi_cs_n` is low while a phase runs or while control bit 8 (hold) is set. It returns high only when a phase has ended and hold is clear.
- R11: While busy, control writes are ignored entirely: the running phase, the phase field and the hold bit are unchanged.
- R12: A start whose phase code (control bits 2:0) is 6 or 7 launches nothing: busy stays 0 and no serial clock is produced.
- R13: The transmit-data word reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 transmit, 1 received, 2 control, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| qspi_sclk | output | 1 | Serial clock, idles low |
| qspi_cs_n | output | 1 | Chip select, active low |
| qspi_dq_o | output | 4 | Data lanes out |
| qspi_dq_oe | output | 4 | Per-lane output enable |
| qspi_dq_i | input | 4 | Data lanes in |

## Verification
The hardest behaviour to prove from the ports is the one-cycle-late read capture. A slave that changes its data on the rising serial clock edge gives the same received word whether the engine samples at the falling edge or one cycle later.

The bench therefore alternates two slave models during the read sweep. The second model drives each nibble only at the falling edge it belongs to, as a delayed return path would. It first leaves the complement of the first nibble on the lanes. A capture taken at the falling edge itself would then pick up the stale value, and the received word would be wrong.

// File: rtl/qspe_pkg.sv
package qspe_pkg;

  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int CYC_W  = 4;

  localparam logic [1:0] REG_TXD  = 2'd0;
  localparam logic [1:0] REG_RXD  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_STAT = 2'd3;

  localparam int CTRL_GO_BIT   = 31;
  localparam int CTRL_HOLD_BIT = 8;

  typedef enum logic [2:0] {
    PH_CMD1 = 3'd0,
    PH_CMD4 = 3'd1,
    PH_ADDR = 3'd2,
    PH_ALT  = 3'd3,
    PH_TURN = 3'd4,
    PH_READ = 3'd5
  } phase_e;

  function automatic logic phase_valid(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  function automatic logic [CYC_W-1:0] phase_cycles(input logic [2:0] code);
    case (code)
      PH_CMD1: return 4'd8;
      PH_CMD4: return 4'd2;
      PH_ADDR: return 4'd8;
      PH_ALT:  return 4'd6;
      PH_TURN: return 4'd2;
      PH_READ: return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/qspe_sclk_gen.sv
module qspe_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic run,
  output logic sclk,
  output logic fall_now
);

  localparam int HC_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [HC_W-1:0] hcnt_q, hcnt_d;
  logic            sclk_q, sclk_d;
  logic            half_end;

  assign half_end = (hcnt_q == HC_W'(HALF_DIV - 1));

  always_comb begin
    hcnt_d = hcnt_q;
    sclk_d = sclk_q;
    if (launch) begin
      hcnt_d = '0;
      sclk_d = 1'b0;
    end else if (run) begin
      if (half_end) begin
        hcnt_d = '0;
        sclk_d = ~sclk_q;
      end else begin
        hcnt_d = hcnt_q + 1'b1;
      end
    end else begin
      hcnt_d = '0;
      sclk_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      sclk_q <= 1'b0;
    end else begin
      hcnt_q <= hcnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk     = sclk_q;
  assign fall_now = run & sclk_q & half_end;

endmodule

// File: rtl/qspe_tx_shift.sv
module qspe_tx_shift
  import qspe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              shift,
  input  logic              quad,
  output logic [LANES-1:0]  top_nib
);

  logic [WORD_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift) begin
      if (quad) sh_d = {sh_q[WORD_W-LANES-1:0], {LANES{1'b0}}};
      else      sh_d = {sh_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign top_nib = sh_q[WORD_W-1 -: LANES];

endmodule

// File: rtl/qspe_rx_capture.sv
module qspe_rx_capture
  import qspe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample_ev,
  input  logic [LANES-1:0]  dq_in,
  output logic [WORD_W-1:0] word
);

  logic              pend_q;
  logic [WORD_W-1:0] word_q, word_d;

  // Capture happens one system clock after the falling-edge event
  always_comb begin
    word_d = word_q;
    if (clear)       word_d = '0;
    else if (pend_q) word_d = {word_q[WORD_W-LANES-1:0], dq_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      word_q <= '0;
    end else begin
      pend_q <= sample_ev;
      word_q <= word_d;
    end
  end

  assign word = word_q;

endmodule

// File: rtl/qspe_phase_engine.sv
module qspe_phase_engine
  import qspe_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              qspi_sclk,
  output logic              qspi_cs_n,
  output logic [LANES-1:0]  qspi_dq_o,
  output logic [LANES-1:0]  qspi_dq_oe,
  input  logic [LANES-1:0]  qspi_dq_i
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  logic [WORD_W-1:0] txd_q, txd_d;
  logic [2:0]        phase_q, phase_d;
  logic              hold_q, hold_d;
  logic              busy_q, busy_d;
  logic              fin_q, fin_d;
  logic              done_q, done_d;
  logic              rdv_q, rdv_d;
  logic [CYC_W-1:0]  cyc_q, cyc_d;

  logic              ctl_wr, ctl_take, launch, run, fall_now, last_fall;
  logic [CYC_W-1:0]  ncyc;
  logic [WORD_W-1:0] load_val, rx_word;
  logic [LANES-1:0]  tx_nib;
  logic              is_read, is_cmd1;

  assign ctl_wr   = reg_we && (reg_addr == REG_CTRL);
  assign ctl_take = ctl_wr && !busy_q;
  assign launch   = ctl_take && reg_wdata[CTRL_GO_BIT] && phase_valid(reg_wdata[2:0]);
  assign run      = busy_q && !fin_q;
  assign ncyc     = phase_cycles(phase_q);
  assign last_fall = fall_now && (cyc_q == ncyc - 1'b1);
  assign is_read  = (phase_q == PH_READ);
  assign is_cmd1  = (phase_q == PH_CMD1);

  always_comb begin
    case (reg_wdata[2:0])
      PH_CMD1, PH_CMD4: load_val = {txd_q[7:0], 24'd0};
      PH_ALT:           load_val = {txd_q[23:0], 8'd0};
      default:          load_val = txd_q;
    endcase
  end

  always_comb begin
    txd_d   = txd_q;
    phase_d = phase_q;
    hold_d  = hold_q;
    busy_d  = busy_q;
    fin_d   = 1'b0;
    done_d  = done_q;
    rdv_d   = rdv_q;
    cyc_d   = cyc_q;
    if (reg_we && (reg_addr == REG_TXD)) txd_d = reg_wdata;
    if (ctl_take) begin
      phase_d = reg_wdata[2:0];
      hold_d  = reg_wdata[CTRL_HOLD_BIT];
    end
    if (launch) begin
      busy_d = 1'b1;
      done_d = 1'b0;
      rdv_d  = 1'b0;
      cyc_d  = '0;
    end else if (fin_q) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      if (is_read) rdv_d = 1'b1;
    end else if (fall_now) begin
      cyc_d = cyc_q + 1'b1;
      if (last_fall) fin_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      txd_q   <= '0;
      phase_q <= '0;
      hold_q  <= 1'b0;
      busy_q  <= 1'b0;
      fin_q   <= 1'b0;
      done_q  <= 1'b0;
      rdv_q   <= 1'b0;
      cyc_q   <= '0;
    end else begin
      txd_q   <= txd_d;
      phase_q <= phase_d;
      hold_q  <= hold_d;
      busy_q  <= busy_d;
      fin_q   <= fin_d;
      done_q  <= done_d;
      rdv_q   <= rdv_d;
      cyc_q   <= cyc_d;
    end
  end

  qspe_sclk_gen #(.HALF_DIV(HALF_DIV)) sclk_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .launch   (launch),
    .run      (run),
    .sclk     (qspi_sclk),
    .fall_now (fall_now)
  );

  qspe_tx_shift tx_i (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (launch),
    .load_val (load_val),
    .shift    (fall_now),
    .quad     (!is_cmd1),
    .top_nib  (tx_nib)
  );

  qspe_rx_capture rx_i (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clear     (launch && (reg_wdata[2:0] == PH_READ)),
    .sample_ev (fall_now && is_read),
    .dq_in     (qspi_dq_i),
    .word      (rx_word)
  );

  always_comb begin
    qspi_dq_o  = '0;
    qspi_dq_oe = '0;
    if (busy_q) begin
      case (phase_q)
        PH_CMD1: begin
          qspi_dq_o  = {3'b000, tx_nib[LANES-1]};
          qspi_dq_oe = 4'b0001;
        end
        PH_CMD4, PH_ADDR, PH_ALT: begin
          qspi_dq_o  = tx_nib;
          qspi_dq_oe = '1;
        end
        default: begin
          qspi_dq_o  = '0;
          qspi_dq_oe = '0;
        end
      endcase
    end
  end

  assign qspi_cs_n = ~(hold_q | busy_q);

  always_comb begin
    case (reg_addr)
      REG_TXD:  reg_rdata = txd_q;
      REG_RXD:  reg_rdata = rx_word;
      REG_CTRL: reg_rdata = {23'd0, hold_q, 5'd0, phase_q};
      default:  reg_rdata = {29'd0, rdv_q, done_q, busy_q};
    endcase
  end

endmodule

// File: rtl/qspe_phase_engine_chk.sv
module qspe_phase_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        rdv,
  input logic [2:0]  phase,
  input logic        hold,
  input logic        reg_we,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        sclk,
  input logic        cs_n,
  input logic [3:0]  dq_oe
);

  // R8
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);

  // R10
  cs_during_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cs_n);

  // R11
  busy_ctl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && reg_addr == 2'd2) |=> ($stable(phase) && $stable(hold)));

  // R6
  lanes_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (phase == 3'd4 || phase == 3'd5)) |-> (dq_oe == 4'd0));

  // R9
  done_with_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy));

  // R12
  reserved_no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && reg_addr == 2'd2 && reg_wdata[2:0] > 3'd5) |=> !busy);

  // R7
  rdv_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdv) |-> (phase == 3'd5 && $fell(busy)));

endmodule

bind qspe_phase_engine qspe_phase_engine_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .busy      (busy_q),
  .done      (done_q),
  .rdv       (rdv_q),
  .phase     (phase_q),
  .hold      (hold_q),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .sclk      (qspi_sclk),
  .cs_n      (qspi_cs_n),
  .dq_oe     (qspi_dq_oe)
);

// File: tb/qspe_phase_engine_tb_top.sv
`timescale 1ns/1ps
module qspe_phase_engine_tb_top;

  localparam int HD = 2;

  logic        clk;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        qspi_sclk;
  logic        qspi_cs_n;
  logic [3:0]  qspi_dq_o;
  logic [3:0]  qspi_dq_oe;
  logic [3:0]  qspi_dq_i;

  qspe_phase_engine #(.HALF_DIV(HD)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .qspi_sclk  (qspi_sclk),
    .qspi_cs_n  (qspi_cs_n),
    .qspi_dq_o  (qspi_dq_o),
    .qspi_dq_oe (qspi_dq_oe),
    .qspi_dq_i  (qspi_dq_i)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int          n_chk = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  int          rise_cnt = 0;
  int          fall_cnt = 0;
  bit          late_mode = 1'b0;
  logic [31:0] rd_word = '0;
  logic [3:0]  cap_o  [16];
  logic [3:0]  cap_oe [16];

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // slave model, early variant: nibble presented at the rising edge
  initial forever begin
    @(posedge qspi_sclk);
    if (rise_cnt < 16) begin
      cap_o[rise_cnt]  = qspi_dq_o;
      cap_oe[rise_cnt] = qspi_dq_oe;
    end
    if (!late_mode && rise_cnt < 8) qspi_dq_i = rd_word[31 - 4*rise_cnt -: 4];
    rise_cnt++;
  end

  // slave model, delayed variant: nibble appears only at its falling edge
  initial forever begin
    @(negedge qspi_sclk);
    if (late_mode && fall_cnt < 8) qspi_dq_i = rd_word[31 - 4*fall_cnt -: 4];
    fall_cnt++;
  end

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(output int n, output logic [31:0] st0, output logic cs0);
    n = 0;
    reg_we = 1'b0; reg_addr = 2'd3;
    #1;
    st0 = reg_rdata; cs0 = qspi_cs_n;
    while (reg_rdata[0] && n < 4000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic start_phase(input logic [2:0] ph, input logic [31:0] wd, input logic hold,
                             input logic [31:0] rdw, input bit late);
    write_reg(2'd0, wd);
    rd_word = rdw;
    late_mode = late;
    qspi_dq_i = late ? ~rdw[31:28] : 4'h0;
    rise_cnt = 0; fall_cnt = 0;
    write_reg(2'd2, 32'h8000_0000 | (32'(hold) << 8) | 32'(ph));
  endtask

  function automatic int exp_cycles(input int ph);
    case (ph)
      0: return 8; 1: return 2; 2: return 8; 3: return 6; 4: return 2; default: return 8;
    endcase
  endfunction

  function automatic string req_of(input int ph);
    case (ph)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5"; 4: return "R6"; default: return "R7";
    endcase
  endfunction

  function automatic logic [31:0] pat(input int p);
    if (p == 0) return 32'h0;
    if (p == 1) return 32'hFFFF_FFFF;
    return (32'h9E37_79B9 * p) ^ 32'h5A5A_1234;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, st0, wd, rdw, act, ex, msk;
    logic        cs0;
    int          nb, ncy, oe_bad;
    logic [3:0]  exp_oe;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0; qspi_dq_i = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    #1;
    chk("R1", "cs_n", 32'(qspi_cs_n), 32'd1);
    chk("R1", "sclk", 32'(qspi_sclk), 32'd0);
    chk("R1", "dq_oe", 32'(qspi_dq_oe), 32'd0);
    read_reg(2'd2, v); chk("R1", "ctrl", v, 32'd0);
    read_reg(2'd3, v); chk("R1", "status", v, 32'd0);
    read_reg(2'd1, v); chk("R1", "rxdata", v, 32'd0);

    // R13 transmit word readback
    write_reg(2'd0, 32'hC0DE_5EED);
    read_reg(2'd0, v); chk("R13", "txd readback", v, 32'hC0DE_5EED);

    // sweep over every phase and several data patterns
    for (int ph = 0; ph < 6; ph++) begin
      for (int p = 0; p < 4; p++) begin
        wd = pat(p);
        rdw = pat(p + 3);
        ncy = exp_cycles(ph);
        start_phase(3'(ph), wd, 1'b0, rdw, p[0]);
        wait_idle(nb, st0, cs0);
        repeat (2) @(negedge clk);
        chk(req_of(ph), "serial clocks", 32'(rise_cnt), 32'(ncy));
        chk("R8", "busy cycles", 32'(nb), 32'(2*HD*ncy + 1));
        chk("R9", "status at start", st0, 32'd1);
        chk("R10", "cs_n during phase", 32'(cs0), 32'd0);
        read_reg(2'd3, v);
        chk("R9", "status at end", v, (ph == 5) ? 32'd6 : 32'd2);
        chk("R10", "cs_n after phase", 32'(qspi_cs_n), 32'd1);
        chk("R8", "sclk idle", 32'(qspi_sclk), 32'd0);
        exp_oe = (ph == 0) ? 4'b0001 : (ph >= 4) ? 4'b0000 : 4'b1111;
        oe_bad = 0;
        act = '0;
        for (int i = 0; i < ncy && i < 16; i++) begin
          if (cap_oe[i] !== exp_oe) oe_bad++;
          if (ph == 0) act = (act << 1) | 32'(cap_o[i][0]);
          else         act = (act << 4) | 32'(cap_o[i]);
        end
        chk(req_of(ph), "lane enables", 32'(oe_bad), 32'd0);
        if (ph == 0) begin
          chk("R2", "single-lane bits", act, {24'd0, wd[7:0]});
        end else if (ph <= 3) begin
          msk = (ncy == 8) ? 32'hFFFF_FFFF : ((32'd1 << (4*ncy)) - 32'd1);
          ex = wd & msk;
          chk(req_of(ph), "quad nibbles", act, ex);
        end else if (ph == 5) begin
          read_reg(2'd1, v);
          chk("R7", late_mode ? "rx word (delayed slave)" : "rx word (early slave)", v, rdw);
        end
      end
    end

    // R10 hold keeps chip select low across phases
    write_reg(2'd2, 32'h0000_0100);
    #1 chk("R10", "cs_n on hold", 32'(qspi_cs_n), 32'd0);
    start_phase(3'd0, 32'h0000_00EB, 1'b1, 32'd0, 1'b0);
    wait_idle(nb, st0, cs0);
    repeat (3) @(negedge clk);
    #1 chk("R10", "cs_n held between phases", 32'(qspi_cs_n), 32'd0);
    start_phase(3'd2, 32'h1234_5678, 1'b1, 32'd0, 1'b0);
    wait_idle(nb, st0, cs0);
    #1 chk("R10", "cs_n held after address", 32'(qspi_cs_n), 32'd0);
    write_reg(2'd2, 32'h0000_0000);
    #1 chk("R10", "cs_n released", 32'(qspi_cs_n), 32'd1);

    // R11 control writes while busy are dropped
    start_phase(3'd2, 32'hA1B2_C3D4, 1'b0, 32'd0, 1'b0);
    repeat (10) @(negedge clk);
    write_reg(2'd2, 32'h8000_0100);
    wait_idle(nb, st0, cs0);
    chk("R11", "phase ran to its length", 32'(rise_cnt), 32'd8);
    read_reg(2'd2, v);
    chk("R11", "ctrl unchanged", v, 32'd2);
    chk("R11", "cs_n not held", 32'(qspi_cs_n), 32'd1);

    // R12 reserved phase codes start nothing
    for (int c = 6; c < 8; c++) begin
      rise_cnt = 0;
      write_reg(2'd2, 32'h8000_0000 | 32'(c));
      repeat (8) @(negedge clk);
      read_reg(2'd3, v);
      chk("R12", "status after reserved start", v, 32'd2);
      chk("R12", "no serial clocks", 32'(rise_cnt), 32'd0);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule